// File: doc/BRIEF.md
# DMA Read Request Engine

The engine takes host read jobs, each a 64-bit start address and a byte count, and cuts them into a series of bus read requests. Each request is as large as the engine allows. The cap is the smaller of two limits: a burst size held in the control register, and a maximum read request size supplied on a separate input. The engine accepts one job at a time. It walks the address forward request by request and steps only when the downstream side takes the current request.

The same block holds the engine's control register and a latched error status register, both behind a simple write/read port. Error sources arrive as single-cycle pulses. They are latched and cleared by a write of ones. The latched set is masked by per-source enables and merged into one attention output. A job whose byte range starts below the 4 GB line and runs past it is rejected outright and latched as a fatal address overflow. Clearing the enable bit lets the job in flight drain before the engine stops, and the enable bit reports the halt state. A self-clearing soft reset bit drops the job in flight and clears the error flags.

Top module: `rdreq_engine`

## Requirements
- R1: The burst code in control bits 17:16 selects the burst size: 0 gives 128 bytes, 1 gives 256, 2 gives 512 and 3 gives 4096.
- R2: Each request is sized to the smaller of the burst size and the size coded on `max_rd_code_i` (same encoding as R1), and the last request of a job carries whatever bytes remain.
- R3: A job with a nonzero length whose start is below 2^32 and whose end (start plus length) is above 2^32 issues no request and sets status bit 7. A job ending exactly at 2^32 is legal.
- R4: Control bit 1 (enable) resets to 1. While it is 0 no new job is accepted, but the job already accepted runs to completion.
- R5: Control bit 1 reads as 1 while the enable is set or a job is still in flight, and reads as 0 only once the engine is disabled and idle.
- R6: Writing 1 to control bit 0 makes it read 1 in the following cycle and 0 after that. In that cycle no request is presented and no job accepted, and at its end the engine is idle and all status bits are clear.
- R7: Status bits 6:0 latch pulses on `err_pulse_i` bit for bit (0 target abort, 1 master abort, 2 parity, 3 FIFO overrun, 4 FIFO underrun, 5 FIFO overread, 6 local write longer than the job). Status bit 7 is the address overflow. Control bits 9:2 enable status bits 7:0, and `attn_o` is the OR of each status bit ANDed with its enable.
- R8: Control bits 15:10 and 31:18 always read as zero whatever is written to them.
- R9: Consecutive requests of a job advance the address by the length of the previous request. A new request appears only after the previous one was taken with `req_ready_i` high.
- R10: While `req_ready_i` is low, the presented request keeps its valid, address and length unchanged.
- R11: Writing to the status register (address 1) clears each status bit written as 1, unless that source pulses in the same cycle.
- R12: `job_ready_o` is high only when the engine is enabled, has no job in flight and is not in a soft reset cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| max_rd_code_i | input | 2 | Maximum read request size code |
| err_pulse_i | input | 7 | Error event pulses, one bit per source |
| job_valid_i | input | 1 | Job offered |
| job_addr_i | input | ADDR_W | Job start host address |
| job_len_i | input | LEN_W | Job length in bytes |
| job_ready_o | output | 1 | Job accepted when high together with valid |
| req_valid_o | output | 1 | Read request presented |
| req_ready_i | input | 1 | Downstream takes the request |
| req_addr_o | output | ADDR_W | Request host address |
| req_len_o | output | LEN_W | Request length in bytes |
| attn_o | output | 1 | Attention: any enabled latched error |

## Verification
Jobs are run under every burst code with the request-size limit both larger and smaller than the burst, so a design that ignores either limit, or swaps the two, produces a wrong first length. Lengths that are not a multiple of the request size show whether the tail is trimmed. A ready line that toggles in a fixed pattern, and one held low for several cycles, show whether the address steps on every handshake and only then. Start addresses just under 4 GB, with one length ending exactly on the boundary and one going past it, show whether the overflow test is placed correctly. Halt and soft reset are each applied with a job stalled mid-flight, which separates draining from flushing.

// File: rtl/rdreq_pkg.sv
package rdreq_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned CODE_W    = 2;
    localparam int unsigned EXT_ERR_N = 7;
    localparam int unsigned ERR_N     = EXT_ERR_N + 1;
    localparam int unsigned ERR_OVF   = ERR_N - 1;

    // control register field positions
    localparam int unsigned CTL_SRST  = 0;
    localparam int unsigned CTL_EN    = 1;
    localparam int unsigned CTL_AEN   = 2;
    localparam int unsigned CTL_BURST = 16;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } split_state_e;

    // byte count selected by a size code
    function automatic logic [12:0] code_bytes(input logic [CODE_W-1:0] code);
        logic [12:0] b;
        case (code)
            2'd0:    b = 13'd128;
            2'd1:    b = 13'd256;
            2'd2:    b = 13'd512;
            default: b = 13'd4096;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rdreq_regs.sv
module rdreq_regs
    import rdreq_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 reg_we_i,
    input  logic                 reg_addr_i,
    input  logic [REG_W-1:0]     reg_wdata_i,
    output logic [REG_W-1:0]     reg_rdata_o,
    input  logic [ERR_N-1:0]     err_set_i,
    input  logic                 busy_i,
    output logic [CODE_W-1:0]    burst_o,
    output logic                 en_o,
    output logic                 srst_o,
    output logic                 attn_o
);

    typedef struct packed {
        logic [CODE_W-1:0] burst;
        logic [ERR_N-1:0]  attn_en;
        logic              en;
        logic              srst;
        logic [ERR_N-1:0]  err;
    } regs_t;

    localparam regs_t RESET_VAL = '{burst: '0, attn_en: '0, en: 1'b1, srst: 1'b0, err: '0};

    regs_t s_d, s_q;

    logic             wr_ctl;
    logic             wr_sts;
    logic [ERR_N-1:0] clr_mask;
    logic             unused_wdata;

    assign wr_ctl       = reg_we_i && (reg_addr_i == 1'b0);
    assign wr_sts       = reg_we_i && (reg_addr_i == 1'b1);
    assign clr_mask     = wr_sts ? reg_wdata_i[ERR_N-1:0] : '0;
    assign unused_wdata = ^{reg_wdata_i[REG_W-1:CTL_BURST+CODE_W],
                            reg_wdata_i[CTL_BURST-1:CTL_AEN+ERR_N]};

    always_comb begin
        s_d      = s_q;
        s_d.srst = 1'b0;
        if (wr_ctl) begin
            s_d.srst    = reg_wdata_i[CTL_SRST];
            s_d.en      = reg_wdata_i[CTL_EN];
            s_d.attn_en = reg_wdata_i[CTL_AEN +: ERR_N];
            s_d.burst   = reg_wdata_i[CTL_BURST +: CODE_W];
        end
        if (s_q.srst) begin
            s_d.err = '0;
        end else begin
            s_d.err = (s_q.err & ~clr_mask) | err_set_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= RESET_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == 1'b0) begin
            reg_rdata_o[CTL_SRST]                = s_q.srst;
            reg_rdata_o[CTL_EN]                  = s_q.en || busy_i;
            reg_rdata_o[CTL_AEN +: ERR_N]        = s_q.attn_en;
            reg_rdata_o[CTL_BURST +: CODE_W]     = s_q.burst;
        end else begin
            reg_rdata_o[ERR_N-1:0]               = s_q.err;
        end
    end

    assign burst_o = s_q.burst;
    assign en_o    = s_q.en;
    assign srst_o  = s_q.srst;
    assign attn_o  = |(s_q.err & s_q.attn_en);

    // R6: soft reset lasts one cycle unless written again
    p_srst_self_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.srst && !(wr_ctl && reg_wdata_i[CTL_SRST]) |=> !s_q.srst);

    // R6: the soft reset cycle leaves every error flag clear
    p_srst_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.srst |=> (s_q.err == '0));

    // R11: write-one clears bits not set again in the same cycle
    p_sts_w1c_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_sts && !s_q.srst |=>
        ((s_q.err & $past(reg_wdata_i[ERR_N-1:0] & ~err_set_i)) == '0));

endmodule

// File: rtl/rdreq_split.sv
module rdreq_split
    import rdreq_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned LEN_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [CODE_W-1:0] burst_i,
    input  logic [CODE_W-1:0] mrrs_i,
    input  logic              job_valid_i,
    input  logic [ADDR_W-1:0] job_addr_i,
    input  logic [LEN_W-1:0]  job_len_i,
    output logic              job_ready_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [LEN_W-1:0]  req_len_o,
    output logic              ovf_o,
    output logic              busy_o
);

    localparam int unsigned LOW_W = 33;
    localparam logic [LOW_W-1:0] FOUR_GB = {1'b1, 32'd0};

    typedef struct packed {
        split_state_e      state;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
    } split_t;

    split_t s_d, s_q;

    logic [CODE_W-1:0] eff_code;
    logic [LEN_W-1:0]  eff_bytes;
    logic [LEN_W-1:0]  chunk;
    logic [LOW_W-1:0]  low_end;
    logic              crosses;
    logic              accept;
    logic              fire;

    always_comb begin
        eff_code    = (burst_i < mrrs_i) ? burst_i : mrrs_i;
        eff_bytes   = LEN_W'(code_bytes(eff_code));
        chunk       = (s_q.remain < eff_bytes) ? s_q.remain : eff_bytes;
        low_end     = {1'b0, job_addr_i[31:0]} + LOW_W'(job_len_i);
        crosses     = (job_addr_i[ADDR_W-1:32] == '0) && (low_end > FOUR_GB);
        job_ready_o = (s_q.state == ST_IDLE) && en_i && !clr_i;
        accept      = job_valid_i && job_ready_o;
        req_valid_o = (s_q.state == ST_BUSY) && !clr_i;
        fire        = req_valid_o && req_ready_i;
        ovf_o       = accept && crosses;

        s_d = s_q;
        if (clr_i) begin
            s_d.state = ST_IDLE;
        end else if (s_q.state == ST_IDLE) begin
            if (accept && !crosses && (job_len_i != '0)) begin
                s_d.state  = ST_BUSY;
                s_d.addr   = job_addr_i;
                s_d.remain = job_len_i;
            end
        end else if (fire) begin
            s_d.addr   = s_q.addr + ADDR_W'(chunk);
            s_d.remain = s_q.remain - chunk;
            if (s_q.remain == chunk) begin
                s_d.state = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{state: ST_IDLE, addr: '0, remain: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_addr_o = s_q.addr;
    assign req_len_o  = chunk;
    assign busy_o     = (s_q.state == ST_BUSY);

    // R2: a request never exceeds either limit and is never empty
    p_len_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o |-> (req_len_o != '0)
                     && (req_len_o <= LEN_W'(code_bytes(burst_i)))
                     && (req_len_o <= LEN_W'(code_bytes(mrrs_i))));

    // R3: a rejected crossing job produces no request
    p_no_req_after_ovf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |=> !req_valid_o);

    // R9: the next request of a job starts where the last one ended
    p_addr_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
        req_valid_o && req_ready_i |=>
        !req_valid_o || (req_addr_o == $past(req_addr_o) + ADDR_W'($past(req_len_o))));

    // R10: a stalled request holds still
    p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
        req_valid_o && !req_ready_i |=>
        req_valid_o && $stable(req_addr_o) && $stable(req_len_o));

    // R12: no job is taken while a request is outstanding
    p_ready_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        job_ready_o |-> !req_valid_o);

endmodule

// File: rtl/rdreq_engine.sv
module rdreq_engine
    import rdreq_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned LEN_W  = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 reg_we_i,
    input  logic                 reg_addr_i,
    input  logic [31:0]          reg_wdata_i,
    output logic [31:0]          reg_rdata_o,
    input  logic [1:0]           max_rd_code_i,
    input  logic [6:0]           err_pulse_i,
    input  logic                 job_valid_i,
    input  logic [ADDR_W-1:0]    job_addr_i,
    input  logic [LEN_W-1:0]     job_len_i,
    output logic                 job_ready_o,
    output logic                 req_valid_o,
    input  logic                 req_ready_i,
    output logic [ADDR_W-1:0]    req_addr_o,
    output logic [LEN_W-1:0]     req_len_o,
    output logic                 attn_o
);

    logic [CODE_W-1:0] burst;
    logic              en;
    logic              srst;
    logic              ovf;
    logic              busy;
    logic [ERR_N-1:0]  err_set;

    assign err_set = {ovf, err_pulse_i};

    rdreq_regs u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .err_set_i   (err_set),
        .busy_i      (busy),
        .burst_o     (burst),
        .en_o        (en),
        .srst_o      (srst),
        .attn_o      (attn_o)
    );

    rdreq_split #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_split (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_i       (srst),
        .en_i        (en),
        .burst_i     (burst),
        .mrrs_i      (max_rd_code_i),
        .job_valid_i (job_valid_i),
        .job_addr_i  (job_addr_i),
        .job_len_i   (job_len_i),
        .job_ready_o (job_ready_o),
        .req_valid_o (req_valid_o),
        .req_ready_i (req_ready_i),
        .req_addr_o  (req_addr_o),
        .req_len_o   (req_len_o),
        .ovf_o       (ovf),
        .busy_o      (busy)
    );

endmodule

// File: tb/rdreq_engine_tb.sv
`timescale 1ns/1ps
module rdreq_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  mrrs = 2'd3;
    logic [6:0]  err_in = '0;
    logic        job_valid = 1'b0;
    logic [63:0] job_addr = '0;
    logic [15:0] job_len = '0;
    logic        job_ready;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [63:0] req_addr;
    logic [15:0] req_len;
    logic        attn;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    rdreq_engine u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .max_rd_code_i(mrrs), .err_pulse_i(err_in),
        .job_valid_i(job_valid), .job_addr_i(job_addr), .job_len_i(job_len), .job_ready_o(job_ready),
        .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr), .req_len_o(req_len),
        .attn_o(attn)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int bsz(input int code);
        return (code == 3) ? 4096 : (128 << code);
    endfunction

    // reference model state
    logic [63:0] qa[$];
    int          ql[$];
    logic [1:0]  m_burst = '0;
    logic [7:0]  m_aen = '0;
    logic        m_en = 1'b1;
    logic        m_srst = 1'b0;
    logic [7:0]  m_err = '0;

    always @(negedge clk) begin : model
        logic        mv, fire, acc, cr, n_srst;
        logic [32:0] e;
        logic [31:0] exp_ctl;
        logic [63:0] a;
        int          r, c, sz;
        if (!rst_n) begin
            qa.delete(); ql.delete();
            m_burst = '0; m_aen = '0; m_en = 1'b1; m_srst = 1'b0; m_err = '0;
        end else begin
            mv = (qa.size() != 0) && !m_srst;
            check(req_valid == mv, "R9", "req_valid", req_valid, mv);
            if (mv && req_valid) begin
                check(req_addr == qa[0], "R9", "req_addr", req_addr, qa[0]);
                check(int'(req_len) == ql[0], "R2", "req_len", req_len, ql[0]);
            end
            check(job_ready == (m_en && qa.size() == 0 && !m_srst), "R12", "job_ready",
                  job_ready, (m_en && qa.size() == 0 && !m_srst));
            check(attn == |(m_err & m_aen), "R7", "attn", attn, |(m_err & m_aen));
            exp_ctl = {14'b0, m_burst, 6'b0, m_aen, (m_en || qa.size() != 0), m_srst};
            if (reg_addr == 1'b0)
                check(reg_rdata == exp_ctl, "R5", "control read", reg_rdata, exp_ctl);
            else
                check(reg_rdata == {24'b0, m_err}, "R11", "status read", reg_rdata, m_err);

            // advance the model to the state after the next rising edge
            fire = mv && req_ready;
            acc  = job_valid && m_en && (qa.size() == 0) && !m_srst;
            e    = {1'b0, job_addr[31:0]} + 33'(job_len);
            cr   = (job_addr[63:32] == 0) && (e > 33'h1_0000_0000);
            n_srst = reg_we && (reg_addr == 1'b0) && reg_wdata[0];
            if (m_srst) m_err = '0;
            else begin
                if (reg_we && reg_addr == 1'b1) m_err = m_err & ~reg_wdata[7:0];
                m_err = m_err | {acc && cr, err_in};
            end
            if (m_srst) begin
                qa.delete(); ql.delete();
            end else begin
                if (fire) begin
                    void'(qa.pop_front()); void'(ql.pop_front());
                end
                if (acc && !cr) begin
                    sz = (bsz(int'(m_burst)) < bsz(int'(mrrs))) ? bsz(int'(m_burst)) : bsz(int'(mrrs));
                    a = job_addr;
                    r = int'(job_len);
                    while (r > 0) begin
                        c = (r < sz) ? r : sz;
                        qa.push_back(a); ql.push_back(c);
                        a = a + 64'(c);
                        r = r - c;
                    end
                end
            end
            if (reg_we && reg_addr == 1'b0) begin
                m_en = reg_wdata[1]; m_aen = reg_wdata[9:2]; m_burst = reg_wdata[17:16];
            end
            m_srst = n_srst;
        end
    end

    function automatic logic [31:0] mk_ctl(input logic en, input logic [7:0] aen,
                                           input logic [1:0] burst, input logic srst);
        return {14'b0, burst, 6'b0, aen, en, srst};
    endfunction

    task automatic wr_reg(input logic a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    endtask

    task automatic send_job(input logic [63:0] a, input int l);
        @(posedge clk); #1;
        job_addr = a; job_len = 16'(l); job_valid = 1'b1;
        @(negedge clk);
        while (!job_ready) @(negedge clk);
        @(posedge clk); #1;
        job_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (qa.size() != 0) @(negedge clk);
    endtask

    task automatic pulse_err(input logic [6:0] b);
        @(posedge clk); #1 err_in = b;
        @(posedge clk); #1 err_in = '0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin : stim
        logic [63:0] a0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // reset state (R4: enable reads 1)
        check(reg_rdata == 32'h2, "R4", "reset control", reg_rdata, 32'h2);
        check(!req_valid && job_ready && !attn, "R4", "reset outputs",
              {req_valid, job_ready, attn}, 3'b010);

        // R1: every burst code with a wide request limit
        for (int code = 0; code < 4; code++) begin
            wr_reg(1'b0, mk_ctl(1'b1, 8'h00, 2'(code), 1'b0));
            send_job(64'h1000_0000, 5000);
            @(negedge clk);
            check(int'(req_len) == bsz(code), "R1", "first length per code", req_len, bsz(code));
            wait_idle();
        end

        // R2: request limit below the burst
        @(posedge clk); #1 mrrs = 2'd1;
        send_job(64'h3_0000_0040, 700);
        @(negedge clk);
        check(req_len == 16'd256, "R2", "limit below burst", req_len, 256);
        wait_idle();
        // R2: burst below the limit, tail under toggling ready (R9)
        @(posedge clk); #1 mrrs = 2'd3;
        wr_reg(1'b0, mk_ctl(1'b1, 8'h00, 2'd1, 1'b0));
        send_job(64'h0000_7F00, 300);
        for (int i = 0; i < 12; i++) begin
            @(posedge clk); #1 req_ready = (i % 3) != 0;
        end
        req_ready = 1'b1;
        wait_idle();

        // R10: a stalled request holds
        wr_reg(1'b0, mk_ctl(1'b1, 8'h00, 2'd0, 1'b0));
        req_ready = 1'b0;
        send_job(64'h5000, 256);
        @(negedge clk);
        a0 = req_addr;
        repeat (3) @(negedge clk);
        check(req_valid && req_addr == a0 && req_len == 16'd128, "R10", "stalled request",
              req_addr, a0);
        @(posedge clk); #1 req_ready = 1'b1;
        wait_idle();

        // R3: crossing job rejected, boundary job accepted
        send_job(64'hFFFF_FF00, 512);
        @(negedge clk);
        check(!req_valid, "R3", "no request for crossing job", req_valid, 0);
        @(posedge clk); #1 reg_addr = 1'b1;
        @(negedge clk);
        check(reg_rdata[7], "R3", "overflow flag", reg_rdata, 32'h80);
        @(posedge clk); #1 reg_addr = 1'b0;
        send_job(64'hFFFF_FF00, 256);
        @(negedge clk);
        check(req_valid && req_addr == 64'hFFFF_FF00, "R3", "job ending at 4 GB", req_valid, 1);
        wait_idle();

        // R7: attention masking
        check(!attn, "R7", "flag masked", attn, 0);
        wr_reg(1'b0, mk_ctl(1'b1, 8'h80, 2'd0, 1'b0));
        @(negedge clk);
        check(attn, "R7", "flag enabled", attn, 1);
        pulse_err(7'h04);
        // R11: clear the overflow flag only
        wr_reg(1'b1, 32'h80);
        @(posedge clk); #1 reg_addr = 1'b1;
        @(negedge clk);
        check(!attn && reg_rdata == 32'h04, "R11", "write-one clear", reg_rdata, 32'h04);
        @(posedge clk); #1 reg_addr = 1'b0;
        wr_reg(1'b0, mk_ctl(1'b1, 8'h04, 2'd0, 1'b0));
        @(negedge clk);
        check(attn, "R7", "parity enabled", attn, 1);
        wr_reg(1'b1, 32'hFF);

        // R8: reserved bits
        wr_reg(1'b0, 32'hFFFF_FFFE);
        @(negedge clk);
        check(reg_rdata == 32'h0003_03FE, "R8", "reserved read zero", reg_rdata, 32'h0003_03FE);
        wr_reg(1'b0, mk_ctl(1'b1, 8'h00, 2'd0, 1'b0));

        // R4, R5: graceful halt
        req_ready = 1'b0;
        send_job(64'h8000, 1024);
        wr_reg(1'b0, mk_ctl(1'b0, 8'h00, 2'd0, 1'b0));
        @(negedge clk);
        check(reg_rdata[1], "R5", "enable reads 1 while draining", reg_rdata[1], 1);
        check(!job_ready && req_valid, "R4", "draining", {job_ready, req_valid}, 2'b01);
        @(posedge clk); #1 req_ready = 1'b1;
        wait_idle();
        @(negedge clk);
        check(!reg_rdata[1], "R5", "enable reads 0 when halted", reg_rdata[1], 0);
        @(posedge clk); #1 job_addr = 64'hA000; job_len = 16'd128; job_valid = 1'b1;
        repeat (4) @(negedge clk);
        check(!req_valid && !job_ready, "R4", "no job while disabled", {req_valid, job_ready}, 0);
        @(posedge clk); #1 job_valid = 1'b0;
        wr_reg(1'b0, mk_ctl(1'b1, 8'h00, 2'd0, 1'b0));

        // R6: soft reset flushes a stalled job and the flags
        pulse_err(7'h01);
        req_ready = 1'b0;
        send_job(64'h9000, 512);
        wr_reg(1'b0, mk_ctl(1'b1, 8'h00, 2'd0, 1'b1));
        @(negedge clk);
        check(reg_rdata[0] && !req_valid, "R6", "reset cycle", reg_rdata[1:0], 2'b11);
        @(negedge clk);
        check(!reg_rdata[0] && !req_valid && job_ready, "R6", "after reset",
              {reg_rdata[0], req_valid, job_ready}, 3'b001);
        @(posedge clk); #1 reg_addr = 1'b1;
        @(negedge clk);
        check(reg_rdata == 32'h0, "R6", "flags cleared", reg_rdata, 0);
        @(posedge clk); #1 reg_addr = 1'b0; req_ready = 1'b1;
        repeat (4) @(negedge clk);

        finish_run();
    end

endmodule